// File: doc/BRIEF.md
# Paged Address Translator with Entry Cache

This block sits between a processor-side request stream and a memory-side request stream. It turns each 16-bit virtual byte address into an 18-bit physical address. The virtual address is split into a 7-bit virtual page number (bits 15:9) and a 9-bit byte offset (bits 8:0). The translated address is a 9-bit physical page number with the unchanged offset appended. Two privilege modes, Exec and User, each have their own page table in main memory. Each table is located by a per-mode base register and indexed by virtual page number.

An eight-entry fully associative cache keeps recently used page-table entries. Each entry is tagged by mode and virtual page. A hit completes the access with no memory traffic. On a miss the block issues one read on a separate page-table port, waits for the response, loads the entry into the cache and then completes the held access. When a slot must be reused, the least recently used slot is evicted. When translation is disabled, addresses pass straight through with the upper two physical bits forced to zero. Writing either base register, or pulsing the flush input, empties the cache.

All three data paths are valid/ready streams. An input request is taken only in the cycle where both `req_valid` and `req_ready` are high. Only one access is in flight at a time, so `req_ready` stays low from acceptance until the translated address has been taken. Once raised, `out_valid` and `pt_req_valid` stay high with stable payloads until their ready signal is seen. The page-table response has no ready signal: the block always accepts it.

Top module: `page_xlate`

## Requirements
- R1: While `xlate_en` is low, an accepted request produces `out_paddr` = {2'b00, `req_vaddr`} in the next cycle, and no page-table read is issued.
- R2: While `xlate_en` is high, `out_paddr[8:0]` equals the request's offset bits and `out_paddr[17:9]` is the physical page number of the matching entry.
- R3: On a miss, one page-table read is issued at address base(mode) + 2 × page number. Base registers are word aligned: bit 0 of a written base is forced to 0. A returned entry is valid when bit 15 is 1, and bits 8:0 hold the physical page number.
- R4: A repeated access to a cached page and mode hits. `out_valid` rises in the cycle after acceptance, and no page-table read is made.
- R5: Entries are tagged by mode. The same page number in the other mode misses, uses that mode's base, and does not displace the first mode's entry.
- R6: A fill takes the lowest-numbered empty slot if one exists. Otherwise it evicts the slot that has gone longest without a hit or fill.
- R7: A fetched entry with bit 15 clear aborts the access. `abort_err` is high for exactly one cycle, in the cycle after the response. No output is produced, and the entry is not cached, so a retry fetches again.
- R8: A one-cycle pulse on `flush` invalidates all eight entries.
- R9: A write to either base register invalidates all entries, and later misses use the new base.
- R10: `out_valid` holds with a stable address until `out_ready`. `pt_req_valid` holds with a stable address until `pt_req_ready`. `req_ready` is low while an access is in flight.
- R11: After reset, `req_ready` is 1, `out_valid`, `pt_req_valid` and `abort_err` are 0, the cache is empty and both bases are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| xlate_en | input | 1 | Translation enable; low means pass-through |
| flush | input | 1 | Invalidate every cache entry |
| base_wr | input | 1 | Write strobe for a table base register |
| base_sel_user | input | 1 | Base register select: 1 = User, 0 = Exec |
| base_wdata | input | 18 | New table base (bit 0 ignored) |
| req_valid | input | 1 | Processor request valid |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 16 | Virtual byte address |
| req_user | input | 1 | Request mode: 1 = User, 0 = Exec |
| req_write | input | 1 | Request is a write (carried through) |
| out_valid | output | 1 | Translated request valid |
| out_ready | input | 1 | Memory side takes the translated request |
| out_paddr | output | 18 | Physical byte address |
| out_write | output | 1 | Write flag of the translated request |
| pt_req_valid | output | 1 | Page-table read request valid |
| pt_req_ready | input | 1 | Memory accepts the page-table read |
| pt_req_addr | output | 18 | Byte address of the page-table entry |
| pt_rsp_valid | input | 1 | Page-table read data valid |
| pt_rsp_data | input | 16 | Page-table entry (bit 15 valid, bits 8:0 page) |
| abort_err | output | 1 | One-cycle pulse: access aborted on an invalid entry |

## Verification
A stale or corrupt cache entry shows up as a wrong upper address field at the very next access to that page. A lost entry or a wrong mode tag shows up instead as an unexpected page-table read, and the hit latency grows from one cycle to three. A wrong recency order only appears once all eight slots are full and a ninth page is filled. The bench therefore fills the cache completely, reorders it with hits, and checks which later page needs a fetch. Errors in the miss path show at the page-table port as a wrong fetch address in the cycle after acceptance, or as a missing or lingering abort pulse.

// File: rtl/pxl_pkg.sv
package pxl_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_FETCH = 2'd1,
    S_WAIT  = 2'd2,
    S_OUT   = 2'd3
  } xl_state_e;

  localparam int MODE_EXEC = 0;
  localparam int MODE_USER = 1;
endpackage

// File: rtl/pxl_tag_store.sv
module pxl_tag_store #(
  parameter int N     = 8,
  parameter int VPN_W = 7,
  parameter int PPN_W = 9,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             lk_user,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  output logic [PPN_W-1:0] hit_ppn,
  output logic [N-1:0]     vld_vec,
  input  logic             inv_all,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic             fill_user,
  input  logic [PPN_W-1:0] fill_ppn
);
  logic [N-1:0]     vld_q;
  logic [N-1:0]     usr_q;
  logic [VPN_W-1:0] tag_q [N];
  logic [PPN_W-1:0] ppn_q [N];
  logic [N-1:0]     match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        vld_q[i] <= 1'b0;
        usr_q[i] <= 1'b0;
        tag_q[i] <= '0;
        ppn_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (inv_all) begin
          vld_q[i] <= 1'b0;
        end else if (fill_en && fill_idx == IDX_W'(i)) begin
          vld_q[i] <= 1'b1;
          usr_q[i] <= fill_user;
          tag_q[i] <= fill_vpn;
          ppn_q[i] <= fill_ppn;
        end
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = vld_q[g] && (usr_q[g] == lk_user) && (tag_q[g] == lk_vpn);
  end

  always_comb begin
    hit_idx = '0;
    hit_ppn = '0;
    for (int i = 0; i < N; i++) begin
      if (match[i]) begin
        hit_idx = IDX_W'(i);
        hit_ppn = ppn_q[i];
      end
    end
  end

  assign hit     = |match;
  assign vld_vec = vld_q;
endmodule

// File: rtl/pxl_lru.sv
module pxl_lru #(
  parameter int N = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic [N-1:0]     vld_vec,
  output logic [IDX_W-1:0] victim
);
  // ord_q[0] is the most recent slot, ord_q[N-1] the stalest one
  logic [IDX_W-1:0] ord_q [N];
  logic [IDX_W-1:0] ord_d [N];
  logic [IDX_W-1:0] pos;

  always_comb begin
    pos = '0;
    for (int i = 0; i < N; i++) begin
      if (ord_q[i] == touch_idx) pos = IDX_W'(i);
    end
    ord_d[0] = touch_idx;
    for (int i = 1; i < N; i++) begin
      ord_d[i] = (IDX_W'(i) <= pos) ? ord_q[i-1] : ord_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) ord_q[i] <= IDX_W'(i);
    end else if (touch_en) begin
      for (int i = 0; i < N; i++) ord_q[i] <= ord_d[i];
    end
  end

  // empty slots are used first, lowest index wins
  always_comb begin
    victim = ord_q[N-1];
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld_vec[i]) victim = IDX_W'(i);
    end
  end
endmodule

// File: rtl/page_xlate.sv
module page_xlate
  import pxl_pkg::*;
#(
  parameter int VA_W  = 16,
  parameter int OFF_W = 9,
  parameter int PA_W  = 18,
  parameter int N_ENT = 8,
  parameter int PTE_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            xlate_en,
  input  logic            flush,
  input  logic            base_wr,
  input  logic            base_sel_user,
  input  logic [PA_W-1:0] base_wdata,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic            req_user,
  input  logic            req_write,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [PA_W-1:0] out_paddr,
  output logic            out_write,
  output logic            pt_req_valid,
  input  logic            pt_req_ready,
  output logic [PA_W-1:0] pt_req_addr,
  input  logic            pt_rsp_valid,
  input  logic [PTE_W-1:0] pt_rsp_data,
  output logic            abort_err
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int IDX_W = $clog2(N_ENT);
  localparam int PTE_VLD = PTE_W - 1;

  xl_state_e        state_q;
  logic [VPN_W-1:0] hold_vpn;
  logic [OFF_W-1:0] hold_off;
  logic             hold_user;
  logic             hold_wr;
  logic [PA_W-1:0]  pt_addr_q;
  logic [PA_W-1:0]  out_pa_q;
  logic             out_wr_q;
  logic             err_q;
  logic [PA_W-1:0]  base_q [2];

  logic             accept;
  logic [VPN_W-1:0] req_vpn;
  logic [OFF_W-1:0] req_off;
  logic [PA_W-1:0]  tbl_base;
  logic [PA_W-1:0]  ent_addr;
  logic             inv_all;
  logic             hit;
  logic [IDX_W-1:0] hit_idx;
  logic [PPN_W-1:0] hit_ppn;
  logic [N_ENT-1:0] vld_vec;
  logic [IDX_W-1:0] victim;
  logic             rsp_ok;
  logic             fill_en;
  logic             touch_en;
  logic [IDX_W-1:0] touch_idx;
  logic [PPN_W-1:0] rsp_ppn;
  logic             pte_unused;

  assign req_ready = (state_q == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign req_vpn   = req_vaddr[VA_W-1:OFF_W];
  assign req_off   = req_vaddr[OFF_W-1:0];
  assign inv_all   = flush || base_wr;
  assign tbl_base  = req_user ? base_q[MODE_USER] : base_q[MODE_EXEC];
  assign ent_addr  = tbl_base + PA_W'({req_vpn, 1'b0});
  assign rsp_ppn   = pt_rsp_data[PPN_W-1:0];
  assign rsp_ok    = pt_rsp_valid && pt_rsp_data[PTE_VLD];
  assign fill_en   = (state_q == S_WAIT) && rsp_ok;
  assign touch_en  = (accept && xlate_en && hit) || fill_en;
  assign touch_idx = fill_en ? victim : hit_idx;
  assign pte_unused = ^{pt_rsp_data[PTE_VLD-1:PPN_W], base_wdata[0]};

  pxl_tag_store #(
    .N    (N_ENT),
    .VPN_W(VPN_W),
    .PPN_W(PPN_W)
  ) i_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_vpn   (req_vpn),
    .lk_user  (req_user),
    .hit      (hit),
    .hit_idx  (hit_idx),
    .hit_ppn  (hit_ppn),
    .vld_vec  (vld_vec),
    .inv_all  (inv_all),
    .fill_en  (fill_en),
    .fill_idx (victim),
    .fill_vpn (hold_vpn),
    .fill_user(hold_user),
    .fill_ppn (rsp_ppn)
  );

  pxl_lru #(
    .N(N_ENT)
  ) i_lru (
    .clk      (clk),
    .rst_n    (rst_n),
    .touch_en (touch_en),
    .touch_idx(touch_idx),
    .vld_vec  (vld_vec),
    .victim   (victim)
  );

  // per-mode table base registers, word aligned
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q[MODE_EXEC] <= '0;
      base_q[MODE_USER] <= '0;
    end else if (base_wr) begin
      base_q[base_sel_user ? MODE_USER : MODE_EXEC] <= {base_wdata[PA_W-1:1], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      hold_vpn  <= '0;
      hold_off  <= '0;
      hold_user <= 1'b0;
      hold_wr   <= 1'b0;
      pt_addr_q <= '0;
      out_pa_q  <= '0;
      out_wr_q  <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      err_q <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (accept) begin
            hold_vpn  <= req_vpn;
            hold_off  <= req_off;
            hold_user <= req_user;
            hold_wr   <= req_write;
            out_wr_q  <= req_write;
            if (!xlate_en) begin
              out_pa_q <= PA_W'(req_vaddr);
              state_q  <= S_OUT;
            end else if (hit) begin
              out_pa_q <= {hit_ppn, req_off};
              state_q  <= S_OUT;
            end else begin
              pt_addr_q <= ent_addr;
              state_q   <= S_FETCH;
            end
          end
        end
        S_FETCH: begin
          if (pt_req_ready) state_q <= S_WAIT;
        end
        S_WAIT: begin
          if (pt_rsp_valid) begin
            if (pt_rsp_data[PTE_VLD]) begin
              out_pa_q <= {rsp_ppn, hold_off};
              out_wr_q <= hold_wr;
              state_q  <= S_OUT;
            end else begin
              err_q   <= 1'b1;
              state_q <= S_IDLE;
            end
          end
        end
        S_OUT: begin
          if (out_ready) state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign out_valid    = (state_q == S_OUT);
  assign out_paddr    = out_pa_q;
  assign out_write    = out_wr_q;
  assign pt_req_valid = (state_q == S_FETCH);
  assign pt_req_addr  = pt_addr_q;
  assign abort_err    = err_q;
endmodule

// File: rtl/pxl_checker.sv
module pxl_checker #(
  parameter int VA_W  = 16,
  parameter int OFF_W = 9,
  parameter int PA_W  = 18
) (
  input logic            clk,
  input logic            rst_n,
  input logic            xlate_en,
  input logic            req_valid,
  input logic            req_ready,
  input logic [VA_W-1:0] req_vaddr,
  input logic            out_valid,
  input logic            out_ready,
  input logic [PA_W-1:0] out_paddr,
  input logic            out_write,
  input logic            pt_req_valid,
  input logic            pt_req_ready,
  input logic [PA_W-1:0] pt_req_addr,
  input logic            abort_err
);
  a_r1_bypass_addr: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !xlate_en |=> out_valid && out_paddr == PA_W'($past(req_vaddr)));

  a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && xlate_en |=>
      pt_req_valid || (out_valid && out_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])));

  a_r3_entry_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    pt_req_valid |-> !pt_req_addr[0]);

  a_r7_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    abort_err |=> !abort_err);

  a_r7_err_no_output: assert property (@(posedge clk) disable iff (!rst_n)
    abort_err |-> !out_valid);

  a_r10_out_held: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_paddr) && $stable(out_write));

  a_r10_pt_held: assert property (@(posedge clk) disable iff (!rst_n)
    pt_req_valid && !pt_req_ready |=> pt_req_valid && $stable(pt_req_addr));

  a_r10_single_flight: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !out_valid && !pt_req_valid);
endmodule

bind page_xlate pxl_checker #(
  .VA_W (VA_W),
  .OFF_W(OFF_W),
  .PA_W (PA_W)
) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .xlate_en    (xlate_en),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_vaddr   (req_vaddr),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_paddr   (out_paddr),
  .out_write   (out_write),
  .pt_req_valid(pt_req_valid),
  .pt_req_ready(pt_req_ready),
  .pt_req_addr (pt_req_addr),
  .abort_err   (abort_err)
);

// File: tb/test_page_xlate.sv
`timescale 1ns/1ps
module test_page_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xlate_en = 1'b1;
  logic        flush = 1'b0;
  logic        base_wr = 1'b0;
  logic        base_sel_user = 1'b0;
  logic [17:0] base_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_vaddr = '0;
  logic        req_user = 1'b0;
  logic        req_write = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [17:0] out_paddr;
  logic        out_write;
  logic        pt_req_valid;
  logic        pt_req_ready = 1'b1;
  logic [17:0] pt_req_addr;
  logic        pt_rsp_valid = 1'b0;
  logic [15:0] pt_rsp_data = '0;
  logic        abort_err;

  int          n_tests = 0;
  int          n_fail  = 0;
  int          fetches = 0;
  logic [17:0] last_addr = '0;
  logic [17:0] bad_addr = 18'h3FFFF;

  always #10 clk = ~clk;

  page_xlate i_page_xlate (
    .clk(clk), .rst_n(rst_n), .xlate_en(xlate_en), .flush(flush),
    .base_wr(base_wr), .base_sel_user(base_sel_user), .base_wdata(base_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_user(req_user), .req_write(req_write),
    .out_valid(out_valid), .out_ready(out_ready), .out_paddr(out_paddr),
    .out_write(out_write),
    .pt_req_valid(pt_req_valid), .pt_req_ready(pt_req_ready),
    .pt_req_addr(pt_req_addr), .pt_rsp_valid(pt_rsp_valid),
    .pt_rsp_data(pt_rsp_data), .abort_err(abort_err)
  );

  function automatic logic [8:0] exp_ppn(input logic [17:0] a);
    return a[9:1] ^ a[17:9];
  endfunction

  // page-table memory model: answers one cycle after the handshake
  initial begin
    forever begin
      @(negedge clk); #1;
      if (pt_req_valid && pt_req_ready) begin
        last_addr = pt_req_addr;
        fetches++;
        @(negedge clk); #1;
        pt_rsp_valid = 1'b1;
        pt_rsp_data  = {(pt_req_addr != bad_addr), 6'b0, exp_ppn(last_addr)};
        @(negedge clk); #1;
        pt_rsp_valid = 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic [15:0] va, input logic usr, input logic wr,
                        output logic [17:0] pa, output logic owr,
                        output logic er, output int cyc);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_user = usr; req_write = wr;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1; pa = '0; owr = 1'b0;
    while (!out_valid && !abort_err && cyc < 60) begin
      @(negedge clk);
      cyc++;
    end
    if (out_valid) begin pa = out_paddr; owr = out_write; end
    er = abort_err;
  endtask

  task automatic set_base(input logic usr, input logic [17:0] v);
    @(negedge clk);
    base_wr = 1'b1; base_sel_user = usr; base_wdata = v;
    @(negedge clk);
    base_wr = 1'b0;
  endtask

  task automatic pulse_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  function automatic logic [15:0] va_of(input int pg, input logic [8:0] off);
    return {pg[6:0], off};
  endfunction

  task automatic t_reset();
    chk(req_ready == 1'b1, "R11", "req_ready after reset", req_ready, 1);
    chk(!out_valid && !pt_req_valid && !abort_err, "R11", "outputs idle after reset",
        {out_valid, pt_req_valid, abort_err}, 0);
  endtask

  task automatic t_bypass();
    logic [17:0] pa; logic ow, er; int cyc, f0;
    xlate_en = 1'b0; f0 = fetches;
    access(16'hABCD, 1'b1, 1'b0, pa, ow, er, cyc);
    chk(pa == 18'h0ABCD, "R1", "bypass address", pa, 18'h0ABCD);
    chk(fetches == f0 && cyc == 1, "R1", "bypass no fetch", fetches - f0, 0);
    xlate_en = 1'b1;
  endtask

  task automatic t_miss_hit();
    logic [17:0] pa; logic ow, er; int cyc, f0;
    set_base(1'b0, 18'h01000);
    f0 = fetches;
    access(va_of(5, 9'h123), 1'b0, 1'b1, pa, ow, er, cyc);
    chk(fetches == f0 + 1 && last_addr == 18'h0100A, "R3", "miss fetch address", last_addr, 18'h0100A);
    chk(pa == {exp_ppn(18'h0100A), 9'h123}, "R2", "translated address", pa, {exp_ppn(18'h0100A), 9'h123});
    chk(ow == 1'b1 && cyc == 3, "R3", "miss latency", cyc, 3);
    access(va_of(5, 9'h0FF), 1'b0, 1'b0, pa, ow, er, cyc);
    chk(fetches == f0 + 1 && cyc == 1, "R4", "hit latency/no fetch", cyc, 1);
    chk(pa == {exp_ppn(18'h0100A), 9'h0FF}, "R2", "hit address", pa, {exp_ppn(18'h0100A), 9'h0FF});
  endtask

  task automatic t_modes();
    logic [17:0] pa; logic ow, er; int cyc, f0;
    set_base(1'b1, 18'h02000);
    f0 = fetches;
    access(va_of(5, 9'h010), 1'b0, 1'b0, pa, ow, er, cyc);
    access(va_of(5, 9'h010), 1'b1, 1'b0, pa, ow, er, cyc);
    chk(fetches == f0 + 2 && last_addr == 18'h0200A, "R5", "user base used", last_addr, 18'h0200A);
    chk(pa == {exp_ppn(18'h0200A), 9'h010}, "R5", "user address", pa, {exp_ppn(18'h0200A), 9'h010});
    access(va_of(5, 9'h010), 1'b0, 1'b0, pa, ow, er, cyc);
    chk(fetches == f0 + 2 && pa == {exp_ppn(18'h0100A), 9'h010}, "R5", "exec entry kept",
        pa, {exp_ppn(18'h0100A), 9'h010});
  endtask

  task automatic t_lru();
    logic [17:0] pa; logic ow, er; int cyc, f0;
    set_base(1'b0, 18'h00000);
    f0 = fetches;
    for (int p = 0; p < 8; p++) access(va_of(p, 9'h0), 1'b0, 1'b0, pa, ow, er, cyc);
    chk(fetches == f0 + 8, "R6", "eight fills", fetches - f0, 8);
    access(va_of(0, 9'h0), 1'b0, 1'b0, pa, ow, er, cyc);
    access(va_of(8, 9'h0), 1'b0, 1'b0, pa, ow, er, cyc);
    f0 = fetches;
    access(va_of(1, 9'h0), 1'b0, 1'b0, pa, ow, er, cyc);
    chk(fetches == f0 + 1, "R6", "stalest page evicted", fetches - f0, 1);
    access(va_of(0, 9'h0), 1'b0, 1'b0, pa, ow, er, cyc);
    access(va_of(8, 9'h0), 1'b0, 1'b0, pa, ow, er, cyc);
    chk(fetches == f0 + 1, "R6", "recent pages kept", fetches - f0, 1);
  endtask

  task automatic t_invalid();
    logic [17:0] pa; logic ow, er; int cyc, f0;
    bad_addr = 18'd40; f0 = fetches;
    access(va_of(20, 9'h4), 1'b0, 1'b0, pa, ow, er, cyc);
    chk(er == 1'b1 && cyc == 3, "R7", "abort pulse timing", cyc, 3);
    @(negedge clk);
    chk(!abort_err && !out_valid, "R7", "abort single cycle", abort_err, 0);
    access(va_of(20, 9'h4), 1'b0, 1'b0, pa, ow, er, cyc);
    chk(fetches == f0 + 2 && er, "R7", "invalid entry not cached", fetches - f0, 2);
    bad_addr = 18'h3FFFF;
  endtask

  task automatic t_flush();
    logic [17:0] pa; logic ow, er; int cyc, f0;
    access(va_of(3, 9'h0), 1'b0, 1'b0, pa, ow, er, cyc);
    f0 = fetches;
    access(va_of(3, 9'h0), 1'b0, 1'b0, pa, ow, er, cyc);
    pulse_flush();
    access(va_of(3, 9'h0), 1'b0, 1'b0, pa, ow, er, cyc);
    chk(fetches == f0 + 1, "R8", "flush forces refetch", fetches - f0, 1);
  endtask

  task automatic t_base_write();
    logic [17:0] pa; logic ow, er; int cyc, f0;
    f0 = fetches;
    set_base(1'b0, 18'h00401);
    access(va_of(3, 9'h55), 1'b0, 1'b0, pa, ow, er, cyc);
    chk(fetches == f0 + 1 && last_addr == 18'h00406, "R9", "new base after write", last_addr, 18'h00406);
    chk(pa == {exp_ppn(18'h00406), 9'h55}, "R3", "aligned base address", pa, {exp_ppn(18'h00406), 9'h55});
  endtask

  task automatic t_backpressure();
    logic [17:0] pa0;
    out_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va_of(3, 9'h77); req_user = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    pa0 = out_paddr;
    for (int i = 0; i < 4; i++) begin
      chk(out_valid && !req_ready && out_paddr == pa0, "R10", "output held",
          out_paddr, pa0);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    chk(!out_valid && req_ready, "R10", "output released", out_valid, 0);
    pt_req_ready = 1'b0;
    req_valid = 1'b1; req_vaddr = va_of(9, 9'h1); req_user = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk(pt_req_valid && pt_req_addr == 18'h02012, "R10", "table request held",
          pt_req_addr, 18'h02012);
      @(negedge clk);
    end
    pt_req_ready = 1'b1;
    for (int i = 0; i < 10 && !out_valid; i++) @(negedge clk);
    chk(out_valid && out_paddr == {exp_ppn(18'h02012), 9'h1}, "R10", "completes after stall",
        out_paddr, {exp_ppn(18'h02012), 9'h1});
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bypass();
    t_miss_hit();
    t_modes();
    t_lru();
    t_invalid();
    t_flush();
    t_base_write();
    t_backpressure();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule